// File: doc/BRIEF.md
# Asynchronous EPROM Read Controller

This block lets synchronous logic fetch bytes from an external 64K x 8 ultraviolet-erasable EPROM. The EPROM has no clock. A requester presents a 16-bit byte address on a valid/ready handshake. The controller drives the address lines and pulls chip-enable low. After a delay it pulls output-enable low. It holds both strobes until the slowest access limit of the chosen speed grade has passed. It then captures the byte and returns it on a response channel. The response stays valid until the consumer takes it.

Each wait is counted in clock cycles. The count is derived from a nanosecond limit and the clock period in picoseconds. It is the ceiling of the time divided by the period, plus one cycle of margin. The access time is split between two phases:
- a lead phase, with chip-enable alone low;
- an enable phase, with output-enable also low.

The enable phase lasts the output-enable access count. The lead phase takes the remainder. Delaying output-enable in this way never lengthens the full access. After the strobes rise, the controller waits out the bus float interval before the device can be selected again. Between accesses it parks the device in standby with both strobes high.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, and whenever reset is applied, both strobes are high, no response is pending and `req_ready` is 1.
- R2: `req_ready` is 1 only while the controller is idle and no response is waiting. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.
- R3: Chip-enable (`mem_ce_n`) falls on the edge that accepts a request. `mem_addr` then equals the accepted address and stays constant while chip-enable is low.
- R4: Each count is ceil(t_ns*1000/CLK_PS)+1. Output-enable falls exactly `lead` cycles after chip-enable falls, where `lead` is the access count minus the output-enable count. With the default 10 ns clock, speed_sel codes 0/1/2/3 (120/150/200/250 ns grades) give:
  - access counts 13/16/21/26;
  - output-enable counts 6/8/9/11;
  - lead values 7/8/12/15.
- R5: Output-enable is never low while chip-enable is high.
- R6: `rsp_valid` rises (access count + 1) cycles after chip-enable falls. It carries the byte on `mem_data` as it was while both strobes were low. Both strobes rise on that same edge.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold. `rsp_valid` drops on the edge where `rsp_ready` is 1.
- R8: After the strobes rise, chip-enable stays high for at least float count + 2 cycles. The float counts are 6/6/7/7 for codes 0/1/2/3 at 10 ns, from limits of 45/50/55/60 ns.
- R9: `speed_sel` is sampled only on the accepting edge. Changing it during an access does not alter that access's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 16 | Byte address of the request |
| speed_sel | input | 2 | Speed grade code 0..3 |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 8 | Byte read from the device |
| mem_addr | output | 16 | Address lines to the device |
| mem_ce_n | output | 1 | Active-low chip-enable |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_data | input | 8 | Data lines from the device |

## Verification
A corrupted phase counter or state shows up directly at the strobes. Output-enable would then fall one or more cycles away from the expected lead, or `rsp_valid` would rise off its access count. Both are seen within one access, at most 27 cycles. A wrong latched grade gives the wrong timing for every later access, even when `speed_sel` is changed mid-access. A broken response hold or a skipped float wait shows on the next handshake or the next chip-enable fall. The bench measures each of these against cycle counts of its own.

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
  parameter int unsigned CLK_PS = 10000,
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned T_ACC0 = 120,
  parameter int unsigned T_ACC1 = 150,
  parameter int unsigned T_ACC2 = 200,
  parameter int unsigned T_ACC3 = 250,
  parameter int unsigned T_OE0  = 50,
  parameter int unsigned T_OE1  = 70,
  parameter int unsigned T_OE2  = 75,
  parameter int unsigned T_OE3  = 100,
  parameter int unsigned T_FLT0 = 45,
  parameter int unsigned T_FLT1 = 50,
  parameter int unsigned T_FLT2 = 55,
  parameter int unsigned T_FLT3 = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    speed_sel,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_data
);

  function automatic int unsigned to_cyc(input int unsigned t_ns);
    return (t_ns * 1000 + CLK_PS - 1) / CLK_PS + 1;
  endfunction

  localparam int unsigned ACC_C0 = to_cyc(T_ACC0);
  localparam int unsigned ACC_C1 = to_cyc(T_ACC1);
  localparam int unsigned ACC_C2 = to_cyc(T_ACC2);
  localparam int unsigned ACC_C3 = to_cyc(T_ACC3);
  localparam int unsigned OE_C0  = to_cyc(T_OE0);
  localparam int unsigned OE_C1  = to_cyc(T_OE1);
  localparam int unsigned OE_C2  = to_cyc(T_OE2);
  localparam int unsigned OE_C3  = to_cyc(T_OE3);
  localparam int unsigned FLT_C0 = to_cyc(T_FLT0);
  localparam int unsigned FLT_C1 = to_cyc(T_FLT1);
  localparam int unsigned FLT_C2 = to_cyc(T_FLT2);
  localparam int unsigned FLT_C3 = to_cyc(T_FLT3);
  localparam int unsigned SUM_C  = ACC_C0 + ACC_C1 + ACC_C2 + ACC_C3
                                 + FLT_C0 + FLT_C1 + FLT_C2 + FLT_C3;
  localparam int unsigned CW     = $clog2(SUM_C + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ENABLE, S_SAMPLE, S_RELEASE, S_FLOAT
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    grade_q;
  logic [1:0]    g_sel;
  logic [CW-1:0] acc_c, oe_c, flt_c, lead_c;

  assign g_sel = (st == S_IDLE) ? speed_sel : grade_q;

  always_comb begin
    case (g_sel)
      2'd0:    begin acc_c = CW'(ACC_C0); oe_c = CW'(OE_C0); flt_c = CW'(FLT_C0); end
      2'd1:    begin acc_c = CW'(ACC_C1); oe_c = CW'(OE_C1); flt_c = CW'(FLT_C1); end
      2'd2:    begin acc_c = CW'(ACC_C2); oe_c = CW'(OE_C2); flt_c = CW'(FLT_C2); end
      default: begin acc_c = CW'(ACC_C3); oe_c = CW'(OE_C3); flt_c = CW'(FLT_C3); end
    endcase
  end

  assign lead_c    = (acc_c > oe_c) ? acc_c - oe_c : CW'(1);
  assign req_ready = (st == S_IDLE) && !rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      grade_q   <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          mem_addr <= req_addr;
          grade_q  <= speed_sel;
          mem_ce_n <= 1'b0;
          cnt      <= lead_c - CW'(1);
          st       <= S_SETUP;
        end
        S_SETUP: if (cnt == '0) begin
          mem_oe_n <= 1'b0;
          cnt      <= oe_c - CW'(1);
          st       <= S_ENABLE;
        end else cnt <= cnt - CW'(1);
        S_ENABLE: if (cnt == '0) st <= S_SAMPLE;
                  else cnt <= cnt - CW'(1);
        S_SAMPLE: begin
          rsp_data  <= mem_data;
          rsp_valid <= 1'b1;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          st        <= S_RELEASE;
        end
        S_RELEASE: begin
          cnt <= flt_c - CW'(1);
          st  <= S_FLOAT;
        end
        S_FLOAT: if (cnt == '0) st <= S_IDLE;
                 else cnt <= cnt - CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk #(
  parameter int unsigned CLK_PS = 10000,
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned T_FLT0 = 45,
  parameter int unsigned T_FLT1 = 50,
  parameter int unsigned T_FLT2 = 55,
  parameter int unsigned T_FLT3 = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n
);

  function automatic int unsigned to_cyc(input int unsigned t_ns);
    return (t_ns * 1000 + CLK_PS - 1) / CLK_PS + 1;
  endfunction

  function automatic int unsigned min2(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  localparam int unsigned GAP_MIN =
    min2(min2(to_cyc(T_FLT0), to_cyc(T_FLT1)), min2(to_cyc(T_FLT2), to_cyc(T_FLT3))) + 2;

  logic [15:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n)        gap <= '1;
    else if (!mem_ce_n) gap <= '0;
    else if (gap != '1) gap <= gap + 16'd1;
  end

  p_oe_needs_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_strobes_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (mem_ce_n && mem_oe_n));

  p_float_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (32'(gap) >= GAP_MIN));

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
  .CLK_PS(CLK_PS), .AW(AW), .DW(DW),
  .T_FLT0(T_FLT0), .T_FLT1(T_FLT1), .T_FLT2(T_FLT2), .T_FLT3(T_FLT3)
) chk_i (.*);

// File: tb/eprom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  speed_sel = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_data;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_oe_n;
  logic [7:0]  mem_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_rd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .speed_sel(speed_sel), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_data(mem_data)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_data = (!mem_ce_n && !mem_oe_n) ? rom_byte(mem_addr) : 8'h00;

  int acc_t[4] = '{13, 16, 21, 26};
  int oe_t[4]  = '{6, 8, 9, 11};
  int flt_t[4] = '{6, 6, 7, 7};

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  data;
    int          grade;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  int hold_cyc = 0, held = 0;
  int t_ce = 0, t_rise = 0, last_g = 0;
  bit have_rise = 0, run = 0;
  logic prev_ce = 1, prev_oe = 1, prev_rv = 0;
  logic [15:0] prev_addr = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      chk(0, "R6 watchdog", cyc, 0);
      summary();
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      if (prev_ce && !mem_ce_n) begin
        t_ce = cyc;
        chk(mem_addr == q[0].addr, "R3 address", int'(mem_addr), int'(q[0].addr));
        if (have_rise)
          chk(cyc - t_rise >= flt_t[last_g] + 2, "R8 float gap", cyc - t_rise, flt_t[last_g] + 2);
      end
      if (!mem_ce_n && !prev_ce && mem_addr != prev_addr)
        chk(0, "R3 address moved", int'(mem_addr), int'(prev_addr));
      if (prev_oe && !mem_oe_n)
        chk(cyc - t_ce == acc_t[q[0].grade] - oe_t[q[0].grade],
            (q[0].tag == "R9") ? "R9 lead" : "R4 lead",
            cyc - t_ce, acc_t[q[0].grade] - oe_t[q[0].grade]);
      if (!mem_oe_n && mem_ce_n)
        chk(0, "R5 oe without ce", 1, 0);
      if (!prev_rv && rsp_valid) begin
        chk(cyc - t_ce == acc_t[q[0].grade] + 1, q[0].tag, cyc - t_ce, acc_t[q[0].grade] + 1);
        chk(mem_ce_n && mem_oe_n, "R6 strobes up", int'({mem_ce_n, mem_oe_n}), 3);
        t_rise = cyc; last_g = q[0].grade; have_rise = 1; held = 0;
      end
      if (rsp_ready) begin
        rsp_ready = 1'b0;
        chk(!rsp_valid, "R7 valid drop", int'(rsp_valid), 0);
      end else if (rsp_valid) begin
        if (rsp_data != q[0].data)
          chk(0, "R7 data hold", int'(rsp_data), int'(q[0].data));
        if (held >= hold_cyc) begin
          chk(rsp_data == q[0].data, "R6 data", int'(rsp_data), int'(q[0].data));
          void'(q.pop_front());
          rsp_ready = 1'b1;
        end else held++;
      end
    end
    prev_ce = mem_ce_n; prev_oe = mem_oe_n; prev_rv = rsp_valid; prev_addr = mem_addr;
  end

  task automatic send(input logic [15:0] a, input int g, input int next_sel, input string tag);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; speed_sel = 2'(g);
    it.addr = a; it.data = rom_byte(a); it.grade = g; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0; speed_sel = 2'(next_sel);
    chk(!req_ready, "R2 busy", int'(req_ready), 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, "R6 drain", q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n, "R1 strobes", int'({mem_ce_n, mem_oe_n}), 3);
    chk(!rsp_valid, "R1 no response", int'(rsp_valid), 0);
    chk(req_ready, "R1 ready", int'(req_ready), 1);
    run = 1;

    hold_cyc = 0;
    for (int g = 0; g < 4; g++) begin
      send(16'h0000, g, g, "R6 latency");
      send(16'hFFFF, g, g, "R6 latency");
      send(16'h1234 + 16'(g), g, g, "R6 latency");
    end
    drain();

    hold_cyc = 3;
    send(16'h8001, 1, 1, "R7 held");
    send(16'h7FFE, 2, 2, "R7 held");
    drain();

    hold_cyc = 0;
    send(16'hA5A5, 0, 3, "R9");
    send(16'h5A5A, 3, 0, "R9");
    send(16'hC3C3, 1, 2, "R9");
    drain();

    hold_cyc = 1000;
    send(16'h4242, 2, 2, "R6 latency");
    while (!rsp_valid) @(negedge clk);
    rst_n = 1'b0; run = 0;
    q.delete(); have_rise = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R1 response cleared", int'(rsp_valid), 0);
    chk(mem_ce_n && mem_oe_n, "R1 strobes after reset", int'({mem_ce_n, mem_oe_n}), 3);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
    summary();
  end
endmodule